// File: doc/BRIEF.md
# Mean-Square Voltage Interval Accumulator

This block produces, for every measurement interval, the two raw sums a host needs to form the mean-square voltage of a digitized, AC-coupled detector signal. Each incoming ADC sample has a calibrated baseline removed. The corrected value and its square are then added into two running totals at the full sample rate, one sample on every clock.

An external interval timebase marks the last sample of each interval with a one-cycle tick. The pulse counter that works on the same stream uses the same tick. When the tick arrives, the block closes the frame. It publishes both totals with a single-cycle valid strobe and starts the next frame without losing a sample. The strobe follows the tick by a fixed latency that matches the pulse counter's result strobe. The host divides the totals by the frame length, takes the variance and cross-calibrates the result to a count rate. None of that is done here.

Top module: `msv_interval_acc`

## Requirements
- R1: While reset is asserted and after its release, `res_valid_o` is low and `res_sum_o` and `res_sumsq_o` read zero until the first interval closes.
- R2: Each sample is corrected as `sample_i - baseline_i`, both taken as two's-complement 12-bit values sampled in the same cycle. The difference is exact over its whole range of -4095 to +4095. A narrower configured width would saturate it.
- R3: `res_sumsq_o` (unsigned, 48 bits) equals the sum of the squared corrected samples of the frame. A frame is every sample after the previous tick cycle, up to and including the sample presented with `frame_end_i` high.
- R4: `res_sum_o` (two's complement, 32 bits) equals the signed sum of the corrected samples of the same frame.
- R5: `res_valid_o` is high for exactly one cycle per tick, 4 cycles after the cycle in which `frame_end_i` was high. That is the multiplier latency of 2 plus one correction stage and one result stage.
- R6: Between strobes, `res_sum_o` and `res_sumsq_o` hold the last published values.
- R7: Ticks on consecutive cycles give one-sample frames on consecutive strobes, with no sample lost or counted twice.
- R8: The first frame after a reset covers exactly the samples presented since the reset was released. A reset in mid-frame discards the partial frame and any result still in flight.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock, one sample per rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| sample_i | input | 12 | ADC sample, two's complement |
| baseline_i | input | 12 | Calibrated baseline, two's complement, subtracted from each sample |
| frame_end_i | input | 1 | High with the last sample of an interval |
| res_sum_o | output | 32 | Signed sum of corrected samples of the last closed frame |
| res_sumsq_o | output | 48 | Sum of squared corrected samples of the last closed frame |
| res_valid_o | output | 1 | One-cycle strobe marking a newly published result |

## Verification
The bench targets frame edges. With ticks on adjacent cycles, a boundary delayed by a different amount from the data would shift one sample into the neighbouring frame, and the bench would see a single-sample result that does not match. At the extreme corrections of +4095 and -4095, a subtractor one bit too narrow would wrap the sign and corrupt both sums. If the baseline changes inside a frame, a design that latched the baseline at the frame start would misreport the later samples. A reset taken in mid-frame must leave no stale strobe or partial total, and the quiet gaps between strobes expose any output that drifts instead of holding.

// File: rtl/msv_pkg.sv
package msv_pkg;
  localparam int unsigned SAMPLE_W_DEF  = 12;
  localparam int unsigned CORR_W_DEF    = 13;
  localparam int unsigned SQ_ACC_W_DEF  = 48;
  localparam int unsigned SUM_ACC_W_DEF = 32;
  localparam int unsigned MUL_LAT_DEF   = 2;

  // cycles from a tick at the input to the result strobe
  function automatic int unsigned result_latency(input int unsigned mul_lat);
    return mul_lat + 2;
  endfunction
endpackage

// File: rtl/msv_baseline_sub.sv
module msv_baseline_sub #(
  parameter int unsigned SAMPLE_W = 12,
  parameter int unsigned CORR_W   = 13
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic signed [SAMPLE_W-1:0] sample_i,
  input  logic signed [SAMPLE_W-1:0] baseline_i,
  input  logic                       last_i,
  output logic signed [CORR_W-1:0]   corr_o,
  output logic                       last_o
);
  localparam int unsigned DIFF_W = SAMPLE_W + 1;

  logic signed [DIFF_W-1:0] diff;
  logic signed [CORR_W-1:0] corr_d;
  logic signed [CORR_W-1:0] corr_q;
  logic                     last_q;

  assign diff = DIFF_W'(sample_i) - DIFF_W'(baseline_i);

  generate
    if (CORR_W >= DIFF_W) begin : g_exact
      assign corr_d = CORR_W'(diff);
    end else begin : g_clamp
      localparam logic signed [DIFF_W-1:0] HI = DIFF_W'((64'sd1 <<< (CORR_W - 1)) - 1);
      localparam logic signed [DIFF_W-1:0] LO = -HI - DIFF_W'(1);
      always_comb begin
        if (diff > HI)      corr_d = CORR_W'(HI);
        else if (diff < LO) corr_d = CORR_W'(LO);
        else                corr_d = CORR_W'(diff);
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      corr_q <= '0;
      last_q <= 1'b0;
    end else begin
      corr_q <= corr_d;
      last_q <= last_i;
    end
  end

  assign corr_o = corr_q;
  assign last_o = last_q;
endmodule

// File: rtl/msv_square_pipe.sv
module msv_square_pipe #(
  parameter int unsigned IN_W = 13,
  parameter int unsigned LAT  = 2
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic signed [IN_W-1:0] corr_i,
  input  logic                   last_i,
  output logic [2*IN_W-1:0]      sq_o,
  output logic signed [IN_W-1:0] corr_o,
  output logic                   last_o
);
  localparam int unsigned SQ_W = 2 * IN_W;

  logic signed [SQ_W-1:0] prod;
  logic [SQ_W-1:0] sq_d   [LAT];
  logic [SQ_W-1:0] sq_q   [LAT];
  logic [IN_W-1:0] cr_d   [LAT];
  logic [IN_W-1:0] cr_q   [LAT];
  logic            last_d [LAT];
  logic            last_q [LAT];

  assign prod = SQ_W'(corr_i) * SQ_W'(corr_i);

  always_comb begin
    sq_d[0]   = SQ_W'(prod);
    cr_d[0]   = corr_i;
    last_d[0] = last_i;
    for (int k = 1; k < LAT; k++) begin
      sq_d[k]   = sq_q[k-1];
      cr_d[k]   = cr_q[k-1];
      last_d[k] = last_q[k-1];
    end
  end

  generate
    for (genvar g = 0; g < LAT; g++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          sq_q[g]   <= '0;
          cr_q[g]   <= '0;
          last_q[g] <= 1'b0;
        end else begin
          sq_q[g]   <= sq_d[g];
          cr_q[g]   <= cr_d[g];
          last_q[g] <= last_d[g];
        end
      end
    end
  endgenerate

  assign sq_o   = sq_q[LAT-1];
  assign corr_o = $signed(cr_q[LAT-1]);
  assign last_o = last_q[LAT-1];
endmodule

// File: rtl/msv_frame_acc.sv
module msv_frame_acc #(
  parameter int unsigned IN_W      = 13,
  parameter int unsigned SQ_ACC_W  = 48,
  parameter int unsigned SUM_ACC_W = 32
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [2*IN_W-1:0]      sq_i,
  input  logic signed [IN_W-1:0] corr_i,
  input  logic                   last_i,
  output logic [SQ_ACC_W-1:0]    sumsq_o,
  output logic [SUM_ACC_W-1:0]   sum_o,
  output logic                   valid_o
);
  logic [SQ_ACC_W-1:0]  sq_acc_q,  sq_acc_d,  sq_tot;
  logic [SUM_ACC_W-1:0] sum_acc_q, sum_acc_d, sum_tot;
  logic [SQ_ACC_W-1:0]  sq_res_q,  sq_res_d;
  logic [SUM_ACC_W-1:0] sum_res_q, sum_res_d;
  logic                 valid_d,   valid_q;
  logic signed [SUM_ACC_W-1:0] corr_ext;

  assign corr_ext = SUM_ACC_W'(corr_i);

  always_comb begin
    sq_tot    = sq_acc_q + SQ_ACC_W'(sq_i);
    sum_tot   = sum_acc_q + corr_ext;
    sq_acc_d  = sq_tot;
    sum_acc_d = sum_tot;
    sq_res_d  = sq_res_q;
    sum_res_d = sum_res_q;
    valid_d   = 1'b0;
    if (last_i) begin
      sq_acc_d  = '0;
      sum_acc_d = '0;
      sq_res_d  = sq_tot;
      sum_res_d = sum_tot;
      valid_d   = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sq_acc_q  <= '0;
      sum_acc_q <= '0;
      sq_res_q  <= '0;
      sum_res_q <= '0;
      valid_q   <= 1'b0;
    end else begin
      sq_acc_q  <= sq_acc_d;
      sum_acc_q <= sum_acc_d;
      sq_res_q  <= sq_res_d;
      sum_res_q <= sum_res_d;
      valid_q   <= valid_d;
    end
  end

  assign sumsq_o = sq_res_q;
  assign sum_o   = sum_res_q;
  assign valid_o = valid_q;
endmodule

// File: rtl/msv_interval_acc.sv
module msv_interval_acc #(
  parameter int unsigned SAMPLE_W  = msv_pkg::SAMPLE_W_DEF,
  parameter int unsigned CORR_W    = msv_pkg::CORR_W_DEF,
  parameter int unsigned SQ_ACC_W  = msv_pkg::SQ_ACC_W_DEF,
  parameter int unsigned SUM_ACC_W = msv_pkg::SUM_ACC_W_DEF,
  parameter int unsigned MUL_LAT   = msv_pkg::MUL_LAT_DEF
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [SAMPLE_W-1:0]  sample_i,
  input  logic [SAMPLE_W-1:0]  baseline_i,
  input  logic                 frame_end_i,
  output logic [SUM_ACC_W-1:0] res_sum_o,
  output logic [SQ_ACC_W-1:0]  res_sumsq_o,
  output logic                 res_valid_o
);
  localparam int unsigned SQ_W = 2 * CORR_W;

  logic signed [CORR_W-1:0] corr_s1, corr_s3;
  logic                     last_s1, last_s3;
  logic [SQ_W-1:0]          sq_s3;

  msv_baseline_sub #(.SAMPLE_W(SAMPLE_W), .CORR_W(CORR_W)) u_sub (
    .clk        (clk),
    .rst_n      (rst_n),
    .sample_i   ($signed(sample_i)),
    .baseline_i ($signed(baseline_i)),
    .last_i     (frame_end_i),
    .corr_o     (corr_s1),
    .last_o     (last_s1)
  );

  msv_square_pipe #(.IN_W(CORR_W), .LAT(MUL_LAT)) u_sq (
    .clk    (clk),
    .rst_n  (rst_n),
    .corr_i (corr_s1),
    .last_i (last_s1),
    .sq_o   (sq_s3),
    .corr_o (corr_s3),
    .last_o (last_s3)
  );

  msv_frame_acc #(.IN_W(CORR_W), .SQ_ACC_W(SQ_ACC_W), .SUM_ACC_W(SUM_ACC_W)) u_acc (
    .clk     (clk),
    .rst_n   (rst_n),
    .sq_i    (sq_s3),
    .corr_i  (corr_s3),
    .last_i  (last_s3),
    .sumsq_o (res_sumsq_o),
    .sum_o   (res_sum_o),
    .valid_o (res_valid_o)
  );
endmodule

// File: rtl/msv_interval_acc_chk.sv
module msv_interval_acc_chk #(
  parameter int unsigned LAT       = 4,
  parameter int unsigned SQ_ACC_W  = 48,
  parameter int unsigned SUM_ACC_W = 32
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 frame_end_i,
  input logic [SUM_ACC_W-1:0] res_sum_o,
  input logic [SQ_ACC_W-1:0]  res_sumsq_o,
  input logic                 res_valid_o
);
  logic [LAT-1:0] tick_sr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tick_sr <= '0;
    else        tick_sr <= {tick_sr[LAT-2:0], frame_end_i};
  end

  // R5: strobe follows each tick after the fixed latency
  a_r5_strobe_latency: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid_o == tick_sr[LAT-1]);

  // R6: published values stay put between strobes
  a_r6_hold_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !res_valid_o |-> ($stable(res_sum_o) && $stable(res_sumsq_o)));

  // R3: a zero energy total implies a zero signed total
  a_r3_zero_energy: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid_o && res_sumsq_o == '0) |-> res_sum_o == '0);

  // R7: back-to-back strobes carry one-sample frames, so sum squared equals energy
  a_r7_single_sample: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid_o && $past(res_valid_o)) |->
      (64'($signed(res_sum_o)) * 64'($signed(res_sum_o)) == 64'(res_sumsq_o)));

  // R1: no strobe during reset
  always @(posedge clk)
    if (!rst_n) a_r1_reset_quiet: assert (!res_valid_o);
endmodule

bind msv_interval_acc msv_interval_acc_chk #(
  .LAT       (MUL_LAT + 2),
  .SQ_ACC_W  (SQ_ACC_W),
  .SUM_ACC_W (SUM_ACC_W)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .frame_end_i (frame_end_i),
  .res_sum_o   (res_sum_o),
  .res_sumsq_o (res_sumsq_o),
  .res_valid_o (res_valid_o)
);

// File: tb/msv_interval_acc_test.sv
module msv_interval_acc_test;
  logic        clk;
  logic        rst_n;
  logic [11:0] sample_i;
  logic [11:0] baseline_i;
  logic        frame_end_i;
  logic [31:0] res_sum_o;
  logic [47:0] res_sumsq_o;
  logic        res_valid_o;

  msv_interval_acc uut (
    .clk         (clk),
    .rst_n       (rst_n),
    .sample_i    (sample_i),
    .baseline_i  (baseline_i),
    .frame_end_i (frame_end_i),
    .res_sum_o   (res_sum_o),
    .res_sumsq_o (res_sumsq_o),
    .res_valid_o (res_valid_o)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  int          vectors = 0;
  int          errors  = 0;
  int          cyc     = 0;
  string       tag     = "R1";
  longint      m_sq;
  longint      m_sum;
  int          due_q[$];
  longint      exp_sq_q[$];
  longint      exp_sum_q[$];
  logic [47:0] held_sq;
  logic [31:0] held_sum;

  task automatic fail(input string what, input longint act, input longint exp);
    errors++;
    $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
  endtask

  task automatic check_cycle();
    bit exp_v;
    vectors++;
    exp_v = (due_q.size() > 0) && (due_q[0] == cyc);
    if (res_valid_o !== exp_v) fail("R5 strobe", longint'(res_valid_o), longint'(exp_v));
    if (exp_v) begin
      held_sq  = 48'(exp_sq_q[0]);
      held_sum = 32'(exp_sum_q[0]);
      void'(due_q.pop_front());
      void'(exp_sq_q.pop_front());
      void'(exp_sum_q.pop_front());
      if (res_sumsq_o !== held_sq) fail("R3 sumsq", longint'(res_sumsq_o), longint'(held_sq));
      if (res_sum_o !== held_sum)
        fail("R4 sum", longint'($signed(res_sum_o)), longint'($signed(held_sum)));
    end else begin
      if (res_sumsq_o !== held_sq || res_sum_o !== held_sum)
        fail("R6 hold", longint'(res_sumsq_o), longint'(held_sq));
    end
  endtask

  // one sample per call; reference result is due 4 cycles later (R5)
  task automatic step(input int s, input int b, input bit last);
    longint c;
    sample_i    = 12'(s);
    baseline_i  = 12'(b);
    frame_end_i = last;
    c     = longint'(s - b);
    m_sq  = m_sq + c * c;
    m_sum = m_sum + c;
    if (last) begin
      due_q.push_back(cyc + 4);
      exp_sq_q.push_back(m_sq);
      exp_sum_q.push_back(m_sum);
      m_sq  = 0;
      m_sum = 0;
    end
    @(posedge clk); #1;
    cyc++;
    check_cycle();
  endtask

  task automatic do_reset();
    rst_n       = 1'b0;
    sample_i    = '0;
    baseline_i  = '0;
    frame_end_i = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    tag = "R1";
    vectors++;
    if (res_valid_o !== 1'b0 || res_sum_o !== '0 || res_sumsq_o !== '0)
      fail("R1 reset state", longint'(res_sumsq_o), 0);
    due_q.delete();
    exp_sq_q.delete();
    exp_sum_q.delete();
    m_sq     = 0;
    m_sum    = 0;
    held_sq  = '0;
    held_sum = '0;
    cyc      = 0;
    rst_n    = 1'b1;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(0, 0, 1'b0);
  endtask

  initial begin
    do_reset();
    idle(3);

    tag = "R3";
    step(10, 0, 0); step(-20, 0, 0); step(5, 0, 0); step(7, 0, 0); step(-3, 0, 1);
    idle(6);

    tag = "R4";
    for (int i = 0; i < 12; i++) step(-100 - i, 50, i == 11);
    idle(6);

    tag = "R2";
    step(2047, -2048, 1); step(-2048, 2047, 1);
    step(2047, -2048, 0); step(2047, -2048, 1);
    step(-2048, 2047, 0); step(-2048, 2047, 0); step(-2048, 2047, 1);
    idle(6);
    for (int i = 0; i < 10; i++) step(300, (i < 5) ? 100 : -400, i == 9);
    idle(6);

    tag = "R7";
    for (int i = 0; i < 12; i++) step(int'($urandom_range(0, 4095)) - 2048, 17, 1);
    idle(6);

    tag = "R3";
    for (int f = 0; f < 30; f++) begin
      int len;
      int b;
      len = int'($urandom_range(1, 40));
      b   = int'($urandom_range(0, 4095)) - 2048;
      for (int i = 0; i < len; i++)
        step(int'($urandom_range(0, 4095)) - 2048, b, i == len - 1);
      if (f % 5 == 0) idle(int'($urandom_range(0, 7)));
    end
    idle(10);

    tag = "R6";
    idle(20);

    tag = "R8";
    for (int i = 0; i < 5; i++) step(900, 0, 0);
    step(900, 0, 1);
    idle(1);
    do_reset();
    tag = "R8";
    idle(2);
    for (int i = 0; i < 4; i++) step(-50 * (i + 1), 25, i == 3);
    idle(8);

    $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    #2000000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule